// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block turns an arbitrary reference clock into a steady one-microsecond tick and counts those ticks in a free-running up-counter. Software sets the ratio of reference cycles per microsecond as a fraction. The numerator and denominator are each stored as a byte that holds the value minus one. A reference of 12.8 MHz, for example, needs 64 cycles for every 5 microseconds, so the low byte holds 63 and the high byte holds 4.

The tick is produced by a phase accumulator. On each reference cycle the accumulator adds the denominator. When the sum reaches the numerator, the block emits a tick and subtracts the numerator. A non-integer ratio therefore spreads its long and short tick intervals evenly, and the count never drifts from the true fraction. The counter can be frozen from the register port while the tick keeps running. Rewriting the ratio restarts the accumulator phase.

Registers are reached through a simple single-cycle write port with a combinational read. Typical ratio settings are 0x000B for 12 MHz, 0x0019 for 26 MHz, 0x002F for 48 MHz, 0x045F for 19.2 MHz and 0x04BF for 38.4 MHz.

Top module: `usec_tick_counter`

## Requirements
- R1: After reset the counter reads 0, the ratio register reads the CFG_RESET parameter (0x000B by default) and the freeze register reads 0.
- R2: With the high byte 0, a tick occurs once every (L+1) reference cycles, where L is bits 7:0 of the ratio register.
- R3: For a ratio with H <= L, where H is bits 15:8, the number of ticks in the first j cycles after a ratio write is exactly floor(j*(H+1)/(L+1)).
- R4: The counter, read at offset 0x10, rises by exactly one at each clock edge where the tick is high and the counter is not frozen, and it holds otherwise.
- R5: Writing a nonzero value to offset 0x4C freezes the counter, and a freeze read returns 1. Writing zero resumes counting. Ticks continue while the counter is frozen.
- R6: A write to the ratio register at offset 0x14 clears the accumulator. No tick is issued in the cycle of that write.
- R7: When H > L (less than one reference cycle per microsecond), a tick is issued on every cycle.
- R8: The ratio register stores only bits 15:0 of the written data and reads zeros above them. Writes to offset 0x10 or to unmapped offsets change nothing, and unmapped offsets read 0.
- R9: The counter wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| usec_tick | output | 1 | One-cycle microsecond tick |

## Verification
The bench compares the running tick total after every cycle against the exact floor of the fraction for several fractional and integer ratios. An accumulator that mis-handled the n+1 offsets, or that dropped the remainder, would drift by one tick or bunch its ticks together. A ratio rewrite in the middle of a tick interval must push the next tick to a full interval later; a design that kept the old phase would tick early. Further cases cover a freeze that must hold the count while ticks still appear, a ratio faster than the clock that must tick every cycle, writes that must be ignored, and a counter that must roll over to zero rather than saturate.

// File: rtl/usec_pkg.sv
package usec_pkg;

  localparam int REG_ADDR_W = 8;

  localparam logic [REG_ADDR_W-1:0] OFS_COUNT  = 8'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_RATIO  = 8'h14;
  localparam logic [REG_ADDR_W-1:0] OFS_FREEZE = 8'h4C;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_RATIO,
    SEL_FREEZE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [REG_ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_COUNT:  s = SEL_COUNT;
      OFS_RATIO:  s = SEL_RATIO;
      OFS_FREEZE: s = SEL_FREEZE;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/usec_rst_sync.sv
module usec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/usec_regs.sv
module usec_regs
  import usec_pkg::*;
#(
  parameter int                      DATA_W    = 32,
  parameter int                      FIELD_W   = 8,
  parameter logic [2*FIELD_W-1:0]    CFG_RESET = 16'h000B
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [FIELD_W-1:0]    ratio_lo,
  output logic [FIELD_W-1:0]    ratio_hi,
  output logic                  ratio_wr,
  output logic                  frozen
);

  localparam int CFG_W = 2 * FIELD_W;

  reg_sel_e         sel;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;
  logic             frz_q;
  logic             frz_d;
  logic             frz_en;

  always_comb begin
    sel    = decode_addr(addr);
    cfg_en = wr_en && (sel == SEL_RATIO);
    frz_en = wr_en && (sel == SEL_FREEZE);
    cfg_d  = wdata[CFG_W-1:0];
    frz_d  = |wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
    end else if (frz_en) begin
      frz_q <= frz_d;
    end
  end

  assign ratio_lo = cfg_q[FIELD_W-1:0];
  assign ratio_hi = cfg_q[CFG_W-1:FIELD_W];
  assign ratio_wr = cfg_en;
  assign frozen   = frz_q;

endmodule

// File: rtl/usec_frac_tick.sv
module usec_frac_tick #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] ratio_lo,
  input  logic [FIELD_W-1:0] ratio_hi,
  input  logic               clear,
  output logic               tick,
  output logic               live
);

  localparam int SUM_W = FIELD_W + 2;

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_d;
  logic             acc_en;
  logic [SUM_W-1:0] step;
  logic [SUM_W-1:0] period;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;
  logic             reach;
  logic             live_q;

  always_comb begin
    step   = SUM_W'(ratio_hi) + SUM_W'(1);
    period = SUM_W'(ratio_lo) + SUM_W'(1);
    sum    = acc_q + step;
    reach  = (sum >= period);
    rem    = sum - period;
    acc_d  = acc_q;
    acc_en = 1'b0;
    if (clear) begin
      acc_d  = '0;
      acc_en = 1'b1;
    end else if (live_q) begin
      acc_en = 1'b1;
      if (reach) begin
        acc_d = (rem >= period) ? '0 : rem;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  assign tick = live_q & ~clear & reach;
  assign live = live_q;

endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               frozen,
  output logic [COUNT_W-1:0] count
);

  logic [COUNT_W-1:0] cnt_q;
  logic [COUNT_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = tick & ~frozen;
    cnt_d  = cnt_q + COUNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/usec_tick_counter.sv
module usec_tick_counter
  import usec_pkg::*;
#(
  parameter int                   DATA_W    = 32,
  parameter int                   FIELD_W   = 8,
  parameter int                   COUNT_W   = 32,
  parameter logic [2*FIELD_W-1:0] CFG_RESET = 16'h000B
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  usec_tick
);

  localparam int CFG_W = 2 * FIELD_W;

  logic               rst_n_s;
  logic [FIELD_W-1:0] cfg_lo;
  logic [FIELD_W-1:0] cfg_hi;
  logic               cfg_wr;
  logic               frozen;
  logic               tick_live;
  logic [COUNT_W-1:0] count;
  logic [DATA_W-1:0]  count_ext;
  reg_sel_e           rd_sel;

  usec_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  usec_regs #(
    .DATA_W    (DATA_W),
    .FIELD_W   (FIELD_W),
    .CFG_RESET (CFG_RESET)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ratio_lo (cfg_lo),
    .ratio_hi (cfg_hi),
    .ratio_wr (cfg_wr),
    .frozen   (frozen)
  );

  usec_frac_tick #(.FIELD_W(FIELD_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ratio_lo (cfg_lo),
    .ratio_hi (cfg_hi),
    .clear    (cfg_wr),
    .tick     (usec_tick),
    .live     (tick_live)
  );

  usec_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick   (usec_tick),
    .frozen (frozen),
    .count  (count)
  );

  generate
    if (COUNT_W < DATA_W) begin : g_cnt_pad
      assign count_ext = {{(DATA_W-COUNT_W){1'b0}}, count};
    end else begin : g_cnt_full
      assign count_ext = count;
    end
  endgenerate

  always_comb begin
    rd_sel = decode_addr(reg_addr);
    case (rd_sel)
      SEL_COUNT:  reg_rdata = count_ext;
      SEL_RATIO:  reg_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_hi, cfg_lo};
      SEL_FREEZE: reg_rdata = {{(DATA_W-1){1'b0}}, frozen};
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/usec_tick_counter_chk.sv
module usec_tick_counter_chk #(
  parameter int FIELD_W = 8,
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               live,
  input logic               frozen,
  input logic               cfg_wr,
  input logic [FIELD_W-1:0] cfg_lo,
  input logic [FIELD_W-1:0] cfg_hi,
  input logic [COUNT_W-1:0] count
);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frozen) |=> (count == COUNT_W'($past(count) + 1'b1)));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r5_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(count));

  a_r6_no_tick_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> !tick);

  a_r7_fast_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !cfg_wr && (cfg_hi > cfg_lo)) |-> tick);

endmodule

bind usec_tick_counter usec_tick_counter_chk #(
  .FIELD_W (FIELD_W),
  .COUNT_W (COUNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .tick   (usec_tick),
  .live   (tick_live),
  .frozen (frozen),
  .cfg_wr (cfg_wr),
  .cfg_lo (cfg_lo),
  .cfg_hi (cfg_hi),
  .count  (count)
);

// File: tb/usec_tick_counter_bench.sv
module usec_tick_counter_bench;

  localparam logic [7:0] A_CNT = 8'h10;
  localparam logic [7:0] A_CFG = 8'h14;
  localparam logic [7:0] A_FRZ = 8'h4C;

  logic        clk;
  logic        rst_n;
  logic        wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        tick;

  logic        n_wr;
  logic [7:0]  n_addr;
  logic [31:0] n_wdata;
  logic [31:0] n_rdata;
  logic        n_tick;

  int total;
  int bad;
  logic [31:0] exp_cnt;
  logic        frz_m;

  usec_tick_counter u_usec_tick_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .usec_tick(tick)
  );

  usec_tick_counter #(.COUNT_W(6), .CFG_RESET(16'h0000)) u_usec_tick_counter_narrow (
    .clk(clk), .rst_n(rst_n), .reg_wr(n_wr), .reg_addr(n_addr),
    .reg_wdata(n_wdata), .reg_rdata(n_rdata), .usec_tick(n_tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model for R4/R5: one increment per tick while not frozen.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_cnt <= '0;
      frz_m   <= 1'b0;
    end else begin
      if (tick && !frz_m) exp_cnt <= exp_cnt + 1;
      if (wr && addr == A_FRZ) frz_m <= |wdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = A_CNT; wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = A_CNT;
  endtask

  task automatic chk_count(input string req);
    #1;
    check(rdata == exp_cnt, req, rdata, exp_cnt);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd_reg(A_CNT, v); check(v == 32'h0, "R1 count", v, 32'h0);
    rd_reg(A_CFG, v); check(v == 32'h000B, "R1 ratio", v, 32'h000B);
    rd_reg(A_FRZ, v); check(v == 32'h0, "R1 freeze", v, 32'h0);
  endtask

  task automatic t_ratio(input logic [15:0] cfg, input int ncyc, input string req);
    int s, p, ticks, first_bad_j, got_at_bad, exp_at_bad;
    s = int'(cfg[15:8]) + 1;
    p = int'(cfg[7:0]) + 1;
    ticks = 0; first_bad_j = 0; got_at_bad = 0; exp_at_bad = 0;
    wr_reg(A_CFG, {16'h0, cfg});
    for (int j = 1; j <= ncyc; j++) begin
      #1;
      if (tick) ticks++;
      if (first_bad_j == 0 && ticks != (j * s) / p) begin
        first_bad_j = j; got_at_bad = ticks; exp_at_bad = (j * s) / p;
      end
      @(negedge clk);
    end
    check(first_bad_j == 0, req, got_at_bad, exp_at_bad);
    chk_count("R4 count follows ticks");
  endtask

  task automatic t_clear();
    int gap;
    bit seen;
    wr_reg(A_CFG, 32'h000B);
    repeat (6) @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = A_CFG; wdata = 32'h000B;
    #1;
    check(tick == 1'b0, "R6 no tick in write cycle", {31'h0, tick}, 32'h0);
    @(negedge clk);
    wr = 1'b0; addr = A_CNT; wdata = '0;
    gap = 0; seen = 1'b0;
    for (int j = 1; j <= 20 && !seen; j++) begin
      #1;
      if (tick) begin gap = j; seen = 1'b1; end
      @(negedge clk);
    end
    check(gap == 12, "R6 phase restart", gap, 12);
  endtask

  task automatic t_freeze();
    logic [31:0] c0, c1, v;
    int ticks;
    wr_reg(A_CFG, 32'h0003);
    repeat (10) @(negedge clk);
    wr_reg(A_FRZ, 32'h0000_0100);
    rd_reg(A_CNT, c0);
    ticks = 0;
    for (int j = 0; j < 40; j++) begin
      #1; if (tick) ticks++;
      @(negedge clk);
    end
    rd_reg(A_CNT, c1);
    check(c1 == c0, "R5 frozen hold", c1, c0);
    check(ticks == 10, "R5 ticks while frozen", ticks, 10);
    rd_reg(A_FRZ, v);
    check(v == 32'h1, "R5 freeze readback", v, 32'h1);
    wr_reg(A_FRZ, 32'h0);
    repeat (20) @(negedge clk);
    rd_reg(A_CNT, c1);
    check(c1 > c0, "R5 resume", c1, c0 + 1);
    chk_count("R5 model after resume");
  endtask

  task automatic t_fast();
    int ticks;
    wr_reg(A_CFG, 32'h0302);
    ticks = 0;
    for (int j = 0; j < 20; j++) begin
      #1; if (tick) ticks++;
      @(negedge clk);
    end
    check(ticks == 20, "R7 tick every cycle", ticks, 20);
    chk_count("R7 count");
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr_reg(A_CNT, 32'hDEAD_BEEF);
    chk_count("R8 count write ignored");
    wr_reg(A_CFG, 32'hFFFF_0019);
    rd_reg(A_CFG, v);
    check(v == 32'h0019, "R8 ratio width", v, 32'h0019);
    wr_reg(8'h20, 32'h1234_5678);
    rd_reg(8'h20, v);
    check(v == 32'h0, "R8 unmapped read", v, 32'h0);
    rd_reg(A_CFG, v);
    check(v == 32'h0019, "R8 unmapped write ignored", v, 32'h0019);
    rd_reg(A_FRZ, v);
    check(v == 32'h0, "R8 freeze untouched", v, 32'h0);
  endtask

  task automatic t_wrap();
    bit hit;
    hit = 1'b0;
    for (int j = 0; j < 200 && !hit; j++) begin
      @(negedge clk); #1;
      if (n_rdata == 32'd63) hit = 1'b1;
    end
    check(hit, "R9 reached all ones", n_rdata, 32'd63);
    @(negedge clk); #1;
    check(n_rdata == 32'd0, "R9 wrap to zero", n_rdata, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    wr = 1'b0; addr = A_CNT; wdata = '0;
    n_wr = 1'b0; n_addr = A_CNT; n_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ratio(16'h000B, 60, "R2 12 cycles per tick");
    t_ratio(16'h002F, 150, "R2 48 cycles per tick");
    t_ratio(16'h043F, 300, "R3 64 per 5");
    t_ratio(16'h045F, 300, "R3 96 per 5");
    t_ratio(16'h04BF, 500, "R3 192 per 5");
    t_clear();
    t_freeze();
    t_fast();
    t_ignore();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule